// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static RAM Model

This block is a clock-sampled behavioural model of an asynchronous static RAM of 16-bit words, for use inside a larger simulation or emulation fabric. Every clock edge it looks at the control strobes and decodes one of four modes: standby, output-disabled, read or write. Two chip selects of opposite polarity gate the device. The select input `csel_lo_n` is true when low and `csel_hi` is true when high. Two active-low byte-lane enables choose which halves of the word take part in an access.

A write is the overlap of every qualifying strobe. These are both chip selects, the active-low write enable and at least one lane enable. The write completes when any one of those strobes drops. The model then commits the address, data and lane choice that were present in the last cycle of the overlap. Read data is combinational from the array. In the cycle where a write is ending, a read of the same word is forwarded from the pending write. The tri-state outputs are represented by a drive vector with one bit per byte lane. Any lane that is not driven reads as zero on `rd_data`.

The word depth is a parameter, and the address is reduced modulo that depth.

Top module: `sram_dual_sel`

## Requirements
- R1: When `csel_lo_n` is 1 or `csel_hi` is 0, `standby` is 1 and `lane_drive` is 2'b00, whatever the other strobes are.
- R2: With both selects active but both lane enables `lane_en_n` at 2'b11, `standby` is 1, `lane_drive` is 2'b00, and a low write enable writes nothing.
- R3: Selected, with `wr_en_n`=1 and `out_en_n`=1, `standby` is 0 and `lane_drive` is 2'b00.
- R4: In a read (selected, `wr_en_n`=1, `out_en_n`=0), `lane_drive[0]` is the inverse of `lane_en_n[0]` and covers bits 7:0. `lane_drive[1]` is the inverse of `lane_en_n[1]` and covers bits 15:8. A driven lane shows the stored byte, and an undriven lane reads as zero.
- R5: A write is active whenever the device is selected and `wr_en_n`=0, for either level of `out_en_n`. During a write `lane_drive` is 2'b00 and `standby` is 0.
- R6: A write updates only the lanes whose enables are 0. The other lane of the word keeps its earlier value.
- R7: The commit happens at the clock edge that ends the write. It uses the address, data and lane enables sampled in the last cycle of the write. The new value is readable in the cycle after that edge. Each write commits exactly once.
- R8: Any of these four events ends a write: `wr_en_n` rising, `csel_lo_n` rising, `csel_hi` falling, or both lane enables going high.
- R9: A read of the same word in the cycle where a write ends returns the newly written data for the written lanes.
- R10: The word selected is `addr` modulo `DEPTH`. For example, with `DEPTH`=1024, address 0x0405 and address 0x0005 reach the same word.
- R11: Asserting `rst_n` low while a write is open discards that write, and the stored word keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the write tracker |
| csel_lo_n | input | 1 | Chip select, active low |
| csel_hi | input | 1 | Chip select, active high |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| lane_en_n | input | 2 | Byte-lane enables, active low; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| addr | input | 16 | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data; undriven lanes read zero |
| lane_drive | output | 2 | Per-lane output drive (tri-state enable) |
| standby | output | 1 | Device deselected |

## Verification
The assertions check the decode rules on every cycle. They confirm that standby implies no drive and no write, that a lane is driven only while its enable and the output enable are low, and that the output is silent during a write. They also check that a commit lasts a single cycle and that no commit follows reset release. Only the bench scenarios can show what the array actually holds. These scenarios cover partial-lane merges and each of the four ways a write can end. They also show that the last cycle's address and data win, and they cover forwarding in the ending cycle, address wrap and the write that reset discards.

// File: rtl/sram_dsel_pkg.sv
package sram_dsel_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 2;
  localparam int DATA_W    = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {
    MD_STANDBY,
    MD_OUT_OFF,
    MD_READ,
    MD_WRITE
  } sram_mode_e;

  // Both selects true and at least one lane requested.
  function automatic logic chip_active(input logic sel_lo_n, input logic sel_hi,
                                       input logic [NUM_LANES-1:0] lane_n);
    return !sel_lo_n && sel_hi && (lane_n != '1);
  endfunction

  function automatic sram_mode_e decode_mode(input logic sel_lo_n, input logic sel_hi,
                                             input logic oe_n, input logic we_n,
                                             input logic [NUM_LANES-1:0] lane_n);
    if (!chip_active(sel_lo_n, sel_hi, lane_n)) return MD_STANDBY;
    if (!we_n) return MD_WRITE;
    if (!oe_n) return MD_READ;
    return MD_OUT_OFF;
  endfunction

  // Word index: address modulo depth.
  function automatic int unsigned word_index(input logic [15:0] a, input int unsigned depth);
    return int'(a) % depth;
  endfunction
endpackage

// File: rtl/sram_dsel_decode.sv
module sram_dsel_decode
  import sram_dsel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_lo_n,
  input  logic                 sel_hi,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic [NUM_LANES-1:0] lane_n,
  output logic                 wr_strobe,
  output logic [NUM_LANES-1:0] lane_drive,
  output logic                 standby
);
  sram_mode_e mode;

  always_comb begin
    mode       = decode_mode(sel_lo_n, sel_hi, oe_n, we_n, lane_n);
    standby    = (mode == MD_STANDBY);
    wr_strobe  = (mode == MD_WRITE);
    lane_drive = (mode == MD_READ) ? ~lane_n : '0;
  end

  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (lane_drive == '0 && !wr_strobe)); // R1
  AST_DRIVE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_drive & lane_n) == '0); // R4
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_drive) |-> (!oe_n && we_n)); // R3
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (lane_drive == '0 && !standby)); // R5
endmodule

// File: rtl/sram_dsel_wtrack.sv
module sram_dsel_wtrack
  import sram_dsel_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_strobe,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LANES-1:0] lane_en,
  output logic                 commit,
  output logic [IDX_W-1:0]     c_idx,
  output logic [DATA_W-1:0]    c_data,
  output logic [NUM_LANES-1:0] c_lanes
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_strobe;
  end

  // Keep the last cycle's address, data and lanes while the strobe is true.
  always_ff @(posedge clk) begin
    if (wr_strobe) begin
      c_idx   <= idx;
      c_data  <= wdata;
      c_lanes <= lane_en;
    end
  end

  assign commit = rst_n && wr_q && !wr_strobe;

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R7
  AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (c_lanes != '0)); // R6
endmodule

// File: rtl/sram_dsel_array.sv
module sram_dsel_array
  import sram_dsel_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 commit,
  input  logic [IDX_W-1:0]     c_idx,
  input  logic [DATA_W-1:0]    c_data,
  input  logic [NUM_LANES-1:0] c_lanes,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [DATA_W-1:0]    rd_word
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && c_lanes[g]) mem[c_idx] <= c_data[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = mem[rd_idx];
  end
endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
  import sram_dsel_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csel_lo_n,
  input  logic        csel_hi,
  input  logic        out_en_n,
  input  logic        wr_en_n,
  input  logic [1:0]  lane_en_n,
  input  logic [15:0] addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic [1:0]  lane_drive,
  output logic        standby
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                 wr_strobe;
  logic                 commit;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     c_idx;
  logic [DATA_W-1:0]    c_data;
  logic [NUM_LANES-1:0] c_lanes;
  logic [DATA_W-1:0]    arr_word;
  logic                 fwd_match;

  assign idx = IDX_W'(word_index(addr, DEPTH));

  sram_dsel_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_lo_n   (csel_lo_n),
    .sel_hi     (csel_hi),
    .oe_n       (out_en_n),
    .we_n       (wr_en_n),
    .lane_n     (lane_en_n),
    .wr_strobe  (wr_strobe),
    .lane_drive (lane_drive),
    .standby    (standby)
  );

  sram_dsel_wtrack #(.IDX_W(IDX_W)) u_wtrack (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .idx       (idx),
    .wdata     (wr_data),
    .lane_en   (~lane_en_n),
    .commit    (commit),
    .c_idx     (c_idx),
    .c_data    (c_data),
    .c_lanes   (c_lanes)
  );

  sram_dsel_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .commit  (commit),
    .c_idx   (c_idx),
    .c_data  (c_data),
    .c_lanes (c_lanes),
    .rd_idx  (idx),
    .rd_word (arr_word)
  );

  // Forward the pending write to a read of the same word in its final cycle.
  assign fwd_match = commit && (c_idx == idx);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_out
    logic [LANE_W-1:0] lane_val;
    assign lane_val = (fwd_match && c_lanes[g]) ? c_data[g*LANE_W +: LANE_W]
                                                : arr_word[g*LANE_W +: LANE_W];
    assign rd_data[g*LANE_W +: LANE_W] = lane_drive[g] ? lane_val : '0;
  end

  AST_NO_COMMIT_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !commit); // R11
endmodule

// File: tb/sram_dual_sel_tb.sv
module sram_dual_sel_tb;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 1024;

  typedef struct packed {
    logic       sel_lo_n;
    logic       sel_hi;
    logic       oe_n;
    logic       we_n;
    logic [1:0] lane_n;
    logic       exp_sb;
    logic [1:0] exp_drv;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 2'b00},
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 2'b00},
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 2'b00},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 2'b00},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 2'b00},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 2'b00},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 2'b11},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 2'b01},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 2'b10},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csel_lo_n = 1'b1, csel_hi = 1'b0, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [1:0]  lane_en_n = 2'b11;
  logic [15:0] addr = '0, wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  lane_drive;
  logic        standby;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sram_dual_sel #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .csel_lo_n(csel_lo_n), .csel_hi(csel_hi),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .lane_en_n(lane_en_n),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .lane_drive(lane_drive), .standby(standby)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    csel_lo_n = 1'b1; csel_hi = 1'b0; out_en_n = 1'b1; wr_en_n = 1'b1; lane_en_n = 2'b11;
  endtask

  // end_kind: 0 write enable rises, 1 low select rises, 2 high select falls, 3 lanes go high
  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] ln,
                          input logic oe, input int end_kind, input string req);
    @(negedge clk);
    csel_lo_n = 1'b0; csel_hi = 1'b1; wr_en_n = 1'b0; out_en_n = oe;
    lane_en_n = ln; addr = a; wr_data = d;
    #1;
    check({req, " write drives nothing"}, {29'd0, standby, lane_drive}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    case (end_kind)
      0: wr_en_n = 1'b1;
      1: csel_lo_n = 1'b1;
      2: csel_hi = 1'b0;
      default: lane_en_n = 2'b11;
    endcase
    @(posedge clk);
    go_idle();
  endtask

  task automatic rd_check(input logic [15:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    csel_lo_n = 1'b0; csel_hi = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b0;
    lane_en_n = 2'b00; addr = a;
    #1;
    check(req, {16'd0, rd_data}, {16'd0, exp});
    check({req, " drive"}, {30'd0, lane_drive}, 32'd3);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // Reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset standby", {31'd0, standby}, 32'd1);
    check("R1 reset drive", {30'd0, lane_drive}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk);

    // Decode table (R1..R5), address kept away from the directed tests
    addr = 16'h03FF; wr_data = 16'h0000;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      csel_lo_n = VECS[i].sel_lo_n; csel_hi = VECS[i].sel_hi;
      out_en_n = VECS[i].oe_n; wr_en_n = VECS[i].we_n; lane_en_n = VECS[i].lane_n;
      #1;
      check($sformatf("R1 R2 R3 R5 standby row %0d", i), {31'd0, standby}, {31'd0, VECS[i].exp_sb});
      check($sformatf("R4 drive row %0d", i), {30'd0, lane_drive}, {30'd0, VECS[i].exp_drv});
      check($sformatf("R4 undriven lanes zero row %0d", i),
            {16'd0, rd_data & ~{{8{VECS[i].exp_drv[1]}}, {8{VECS[i].exp_drv[0]}}}}, 32'd0);
    end
    go_idle();
    @(posedge clk);

    // R5 R7 R8: full word, ended by write enable rising
    do_write(16'h0010, 16'hA55A, 2'b00, 1'b1, 0, "R5");
    rd_check(16'h0010, 16'hA55A, "R7 R8 end by write enable");
    // R5 with output enable low, ended by low-true select rising
    do_write(16'h0011, 16'h1234, 2'b00, 1'b0, 1, "R5 oe low");
    rd_check(16'h0011, 16'h1234, "R8 end by low select");
    // R6 upper lane only, ended by high select falling
    do_write(16'h0010, 16'hC3FF, 2'b01, 1'b1, 2, "R6");
    rd_check(16'h0010, 16'hC35A, "R6 R8 upper lane only");
    // R6 lower lane only, ended by both lanes going high
    do_write(16'h0011, 16'hFFEE, 2'b10, 1'b1, 3, "R6");
    rd_check(16'h0011, 16'h12EE, "R6 R8 lower lane only");

    // R7: address and data change mid-write; the last cycle wins
    do_write(16'h0020, 16'h0F0F, 2'b00, 1'b1, 0, "R7");
    @(negedge clk);
    csel_lo_n = 1'b0; csel_hi = 1'b1; wr_en_n = 1'b0; out_en_n = 1'b1;
    lane_en_n = 2'b00; addr = 16'h0020; wr_data = 16'h1111;
    @(posedge clk);
    @(negedge clk);
    addr = 16'h0021; wr_data = 16'h2222;
    @(posedge clk);
    @(negedge clk);
    wr_en_n = 1'b1;
    @(posedge clk);
    go_idle();
    rd_check(16'h0021, 16'h2222, "R7 last cycle address");
    rd_check(16'h0020, 16'h0F0F, "R7 earlier address untouched");

    // R9: read of same word in the ending cycle sees the new data
    @(negedge clk);
    csel_lo_n = 1'b0; csel_hi = 1'b1; wr_en_n = 1'b0; out_en_n = 1'b1;
    lane_en_n = 2'b00; addr = 16'h0030; wr_data = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    wr_en_n = 1'b1; out_en_n = 1'b0;
    #1;
    check("R9 forwarded read", {16'd0, rd_data}, 32'h0000BEEF);
    go_idle();
    rd_check(16'h0030, 16'hBEEF, "R9 stored after commit");

    // R10: address wraps modulo depth
    do_write(16'h0405, 16'h7777, 2'b00, 1'b1, 0, "R10");
    rd_check(16'h0005, 16'h7777, "R10 wrap");

    // R11: reset during an open write discards it
    do_write(16'h0040, 16'h1357, 2'b00, 1'b1, 0, "R11");
    @(negedge clk);
    csel_lo_n = 1'b0; csel_hi = 1'b1; wr_en_n = 1'b0; out_en_n = 1'b1;
    lane_en_n = 2'b00; addr = 16'h0040; wr_data = 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    csel_lo_n = 1'b1; csel_hi = 1'b0; wr_en_n = 1'b1; lane_en_n = 2'b11;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    rd_check(16'h0040, 16'h1357, "R11 write discarded by reset");

    go_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule